// File: doc/BRIEF.md
# T1/E1 Transmit Signaling Inserter

This block puts per-channel signaling bits into an outgoing T1 or E1 serial stream. The host writes sixteen 8-bit signaling registers and four 8-bit channel-enable registers through a simple write port. At a multiframe boundary the signaling bank is copied into a shadow buffer. The stream is always built from the shadow, so a host write never disturbs the multiframe that is on the line. The host uses a sticky interrupt flag to learn that a copy has happened and that new values can be written.

Frame timing comes from outside as a bit index, a channel/slot index, a frame index and a multiframe-start strobe. Each cycle carries one serial bit. In T1 the block robs the least significant bit of enabled channels in the signaling frames. In T1 ESF there are four letters per multiframe. In T1 D4 there are two letters, and the C/D positions of each nibble feed the next multiframe, so the shadow reloads only on every second boundary. In E1 the block writes two ABCD nibbles into slot 16 of frames 1 to 15. The output is registered.

Top module: `t1e1_sig_inserter`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at `wr_addr`. Addresses 0..15 are signaling registers. Addresses 16..19 are enable registers, where address 16+k bit j enables channel 8k+j. All other addresses are ignored.
- R2: The shadow copies the signaling bank only at the rising clock edge where `mf_start` is high. A write between boundaries does not change the bits sent in the current multiframe.
- R3: `mf_irq` is set one cycle after every shadow copy and stays set until `irq_clr` is high at an edge with no copy. A copy wins over a clear in the same cycle.
- R4: When the global enable of the current mode is low (`t1_ins_en` for T1, `e1_ins_en` for E1), `data_out` equals `data_in` from one cycle earlier.
- R5: A channel whose enable bit is 0 passes through unchanged.
- R6: Channel n's nibble is held in signaling register n/2. Even n uses bits 7:4 and odd n uses bits 3:0. Within a nibble, bit 3 is A, bit 2 is B, bit 1 is C and bit 0 is D.
- R7: In T1 ESF (`mode_e1`=0, `t1_d4`=0), frame indices 5, 11, 17 and 23 carry A, B, C and D. The letter replaces bit index 7 (the LSB, sent last) of channels 0..23. Every boundary copies the bank.
- R8: In T1 D4 (`t1_d4`=1), frame indices 5 and 11 carry A and B in the multiframe right after a copy. In the multiframe after that, the same frames carry C and D. The copy happens on every second boundary only. The first D4 boundary after reset or after another mode always copies.
- R9: In E1 (`mode_e1`=1), slot 16 of frame f (f = 1..15) carries channel f's A..D at bit indices 0..3 and channel f+15's A..D at bit indices 4..7. Frame 0 and all other slots pass through.
- R10: After reset `data_out` and `mf_irq` are 0, and the registers and the shadow hold zero.
- R11: Every bit that is not inserted appears on `data_out` one cycle after `data_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 5 | Host register address |
| wr_data | input | 8 | Host write data |
| irq_clr | input | 1 | Clears the multiframe flag |
| mode_e1 | input | 1 | 1 = E1, 0 = T1 |
| t1_d4 | input | 1 | In T1: 1 = D4, 0 = ESF |
| t1_ins_en | input | 1 | Global insertion enable, T1 |
| e1_ins_en | input | 1 | Global insertion enable, E1 |
| mf_start | input | 1 | High on the first bit of a multiframe |
| frame_idx | input | 5 | Frame index within the multiframe, from 0 |
| slot_idx | input | 5 | Channel or time slot index, from 0 |
| bit_idx | input | 3 | Bit index within the slot, 0 sent first |
| data_in | input | 1 | Incoming serial bit |
| data_out | output | 1 | Outgoing serial bit, one cycle later |
| mf_irq | output | 1 | Sticky multiframe-copy flag |

## Verification
A corrupt shadow or a missed copy does not show at once. It appears at the next signaling position of an enabled channel, which can be over a thousand bits after the boundary in T1 ESF. The bench therefore compares every output bit of whole multiframes. A wrong D4 half flag shows as A/B being sent where C/D is due, or as a reload one multiframe early, in the very next signaling frame. A wrong copy decision also shows on `mf_irq` one cycle after the boundary.

// File: rtl/sig_ins_pkg.sv
package sig_ins_pkg;
  localparam int SIG_REGS    = 16;
  localparam int REG_W       = 8;
  localparam int NIB_W       = 4;
  localparam int EN_REGS     = 4;
  localparam int T1_CHANS    = 24;
  localparam int CNT_W       = 5;
  localparam int BIT_W       = 3;
  localparam int ADDR_W      = 5;
  localparam int BANK_W      = SIG_REGS * REG_W;
  localparam int CHANS       = EN_REGS * REG_W;
  localparam int EN_BASE     = SIG_REGS;
  localparam int LSB_POS     = REG_W - 1;
  localparam int E1_SIG_SLOT = 16;
  localparam int E1_FRAMES   = 16;
  localparam int E1_PAIR_OFS = E1_FRAMES - 1;

  typedef struct packed {
    logic       hit;
    logic [1:0] letter; // 0 = A .. 3 = D
  } t1_pos_t;

  // Nibble of channel ch: register ch/2, upper half for even channels
  function automatic logic [NIB_W-1:0] nibble_of(input logic [BANK_W-1:0] bank,
                                                 input logic [CNT_W-1:0]  ch);
    int base;
    base = int'(ch >> 1) * REG_W + (ch[0] ? 0 : NIB_W);
    return bank[base +: NIB_W];
  endfunction

  // Which signaling letter a T1 frame carries, if any
  function automatic t1_pos_t t1_position(input logic [CNT_W-1:0] frame,
                                          input logic d4, input logic odd_half);
    t1_pos_t p;
    p = '0;
    if (d4) begin
      if (frame == CNT_W'(5))  begin p.hit = 1'b1; p.letter = odd_half ? 2'd2 : 2'd0; end
      if (frame == CNT_W'(11)) begin p.hit = 1'b1; p.letter = odd_half ? 2'd3 : 2'd1; end
    end else begin
      case (frame)
        CNT_W'(5):  begin p.hit = 1'b1; p.letter = 2'd0; end
        CNT_W'(11): begin p.hit = 1'b1; p.letter = 2'd1; end
        CNT_W'(17): begin p.hit = 1'b1; p.letter = 2'd2; end
        CNT_W'(23): begin p.hit = 1'b1; p.letter = 2'd3; end
        default:    p = '0;
      endcase
    end
    return p;
  endfunction

  function automatic logic letter_bit(input logic [NIB_W-1:0] nib, input logic [1:0] letter);
    return nib[NIB_W-1-int'(letter)];
  endfunction
endpackage

// File: rtl/sig_ins_bank.sv
module sig_ins_bank
  import sig_ins_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [BANK_W-1:0] bank,
  output logic [CHANS-1:0]  chan_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank    <= '0;
      chan_en <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < SIG_REGS; i++)
        if (wr_addr == ADDR_W'(i)) bank[i*REG_W +: REG_W] <= wr_data;
      for (int k = 0; k < EN_REGS; k++)
        if (wr_addr == ADDR_W'(EN_BASE + k)) chan_en[k*REG_W +: REG_W] <= wr_data;
    end
  end
endmodule

// File: rtl/sig_ins_shadow.sv
module sig_ins_shadow
  import sig_ins_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mf_start,
  input  logic              d4_mode,
  input  logic              irq_clr,
  input  logic [BANK_W-1:0] bank,
  output logic [BANK_W-1:0] shadow,
  output logic              odd_half,
  output logic              load,
  output logic              mf_irq
);
  // D4 copies only when the second half of a pair has ended
  assign load = mf_start & (~d4_mode | odd_half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow   <= '0;
      odd_half <= 1'b1;
      mf_irq   <= 1'b0;
    end else begin
      if (load)     shadow   <= bank;
      if (mf_start) odd_half <= ~d4_mode | ~load;
      if (load)         mf_irq <= 1'b1;
      else if (irq_clr) mf_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/sig_ins_pick.sv
module sig_ins_pick
  import sig_ins_pkg::*;
(
  input  logic              mode_e1,
  input  logic              t1_d4,
  input  logic              t1_ins_en,
  input  logic              e1_ins_en,
  input  logic [CNT_W-1:0]  frame_idx,
  input  logic [CNT_W-1:0]  slot_idx,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [BANK_W-1:0] shadow,
  input  logic [CHANS-1:0]  chan_en,
  input  logic              odd_half,
  output logic              ins_hit,
  output logic              ins_bit
);
  t1_pos_t          pos;
  logic [CNT_W-1:0] e1_ch;
  logic [NIB_W-1:0] nib;

  always_comb begin
    ins_hit = 1'b0;
    ins_bit = 1'b0;
    pos     = t1_position(frame_idx, t1_d4, odd_half);
    e1_ch   = frame_idx + (bit_idx[BIT_W-1] ? CNT_W'(E1_PAIR_OFS) : CNT_W'(0));
    nib     = '0;
    if (!mode_e1) begin
      if (t1_ins_en && pos.hit && bit_idx == BIT_W'(LSB_POS) &&
          slot_idx < CNT_W'(T1_CHANS) && chan_en[slot_idx]) begin
        nib     = nibble_of(shadow, slot_idx);
        ins_hit = 1'b1;
        ins_bit = letter_bit(nib, pos.letter);
      end
    end else begin
      if (e1_ins_en && slot_idx == CNT_W'(E1_SIG_SLOT) && frame_idx != '0 &&
          frame_idx < CNT_W'(E1_FRAMES) && chan_en[e1_ch]) begin
        nib     = nibble_of(shadow, e1_ch);
        ins_hit = 1'b1;
        ins_bit = letter_bit(nib, bit_idx[1:0]);
      end
    end
  end
endmodule

// File: rtl/t1e1_sig_inserter.sv
module t1e1_sig_inserter
  import sig_ins_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              irq_clr,
  input  logic              mode_e1,
  input  logic              t1_d4,
  input  logic              t1_ins_en,
  input  logic              e1_ins_en,
  input  logic              mf_start,
  input  logic [CNT_W-1:0]  frame_idx,
  input  logic [CNT_W-1:0]  slot_idx,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              data_in,
  output logic              data_out,
  output logic              mf_irq
);
  logic [BANK_W-1:0] bank;
  logic [BANK_W-1:0] shadow;
  logic [CHANS-1:0]  chan_en;
  logic              odd_half;
  logic              load_pulse;
  logic              ins_hit;
  logic              ins_bit;
  logic              d4_mode;

  assign d4_mode = ~mode_e1 & t1_d4;

  sig_ins_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bank(bank), .chan_en(chan_en)
  );

  sig_ins_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .mf_start(mf_start), .d4_mode(d4_mode),
    .irq_clr(irq_clr), .bank(bank), .shadow(shadow), .odd_half(odd_half),
    .load(load_pulse), .mf_irq(mf_irq)
  );

  sig_ins_pick u_pick (
    .mode_e1(mode_e1), .t1_d4(t1_d4), .t1_ins_en(t1_ins_en),
    .e1_ins_en(e1_ins_en), .frame_idx(frame_idx), .slot_idx(slot_idx),
    .bit_idx(bit_idx), .shadow(shadow), .chan_en(chan_en),
    .odd_half(odd_half), .ins_hit(ins_hit), .ins_bit(ins_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_out <= 1'b0;
    else        data_out <= ins_hit ? ins_bit : data_in;
  end
endmodule

// File: rtl/t1e1_sig_inserter_chk.sv
module t1e1_sig_inserter_chk
  import sig_ins_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             irq_clr,
  input logic             mode_e1,
  input logic             t1_d4,
  input logic             t1_ins_en,
  input logic             e1_ins_en,
  input logic             mf_start,
  input logic [CNT_W-1:0] frame_idx,
  input logic [BIT_W-1:0] bit_idx,
  input logic             data_in,
  input logic             data_out,
  input logic             mf_irq,
  input logic             load_pulse,
  input logic             ins_hit
);
  p_load_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> mf_start);

  p_irq_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> mf_irq);

  p_irq_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !load_pulse) |=> !mf_irq);

  p_global_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e1 ? !e1_ins_en : !t1_ins_en) |=> (data_out == $past(data_in)));

  p_esf_every_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_start && !mode_e1 && !t1_d4) |-> load_pulse);

  p_t1_lsb_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_e1 && bit_idx != BIT_W'(LSB_POS)) |-> !ins_hit);

  p_e1_frame0_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e1 && frame_idx == '0) |-> !ins_hit);

  p_pass_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_hit |=> (data_out == $past(data_in)));
endmodule

bind t1e1_sig_inserter t1e1_sig_inserter_chk u_chk (.*);

// File: tb/t1e1_sig_inserter_tb.sv
module t1e1_sig_inserter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       irq_clr = 1'b0;
  logic       mode_e1 = 1'b0;
  logic       t1_d4 = 1'b0;
  logic       t1_ins_en = 1'b0;
  logic       e1_ins_en = 1'b0;
  logic       mf_start = 1'b0;
  logic [4:0] frame_idx = '0;
  logic [4:0] slot_idx = '0;
  logic [2:0] bit_idx = '0;
  logic       data_in = 1'b0;
  logic       data_out;
  logic       mf_irq;

  always #10 clk = ~clk; // 50 MHz

  t1e1_sig_inserter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_clr(irq_clr), .mode_e1(mode_e1), .t1_d4(t1_d4),
    .t1_ins_en(t1_ins_en), .e1_ins_en(e1_ins_en), .mf_start(mf_start),
    .frame_idx(frame_idx), .slot_idx(slot_idx), .bit_idx(bit_idx),
    .data_in(data_in), .data_out(data_out), .mf_irq(mf_irq)
  );

  typedef struct {
    bit    exp_d;
    bit    exp_irq;
    string tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;

  // reference state
  bit [7:0]  m_bank[16];
  bit [7:0]  m_shadow[16];
  bit [31:0] m_en = '0;
  bit        m_second = 1'b1;
  bit        m_irq = 1'b0;

  bit        pend_wr = 1'b0;
  bit [4:0]  pend_addr = '0;
  bit [7:0]  pend_data = '0;
  bit        pend_clr = 1'b0;

  function automatic bit ref_letter(input int ch, input int letter);
    bit [7:0] r;
    bit [3:0] nib;
    r   = m_shadow[ch / 2];
    nib = (ch % 2 == 0) ? r[7:4] : r[3:0];
    return nib[3 - letter];
  endfunction

  task automatic step(input bit mfs, input int fr, input int ch, input int bt);
    item_t it;
    int    letter;
    int    who;
    bit    din;
    bit    is_d4;
    bit    load;
    @(negedge clk);
    din       = 1'($urandom);
    mf_start  = mfs;
    frame_idx = 5'(fr);
    slot_idx  = 5'(ch);
    bit_idx   = 3'(bt);
    data_in   = din;
    wr_en     = pend_wr;
    wr_addr   = pend_addr;
    wr_data   = pend_data;
    irq_clr   = pend_clr;
    pend_wr   = 1'b0;
    pend_clr  = 1'b0;

    it.exp_d = din;
    it.tag   = "R11 pass";
    letter   = -1;
    who      = ch;
    if (!mode_e1) begin
      if (t1_d4) begin
        if (fr == 5)  letter = m_second ? 2 : 0;
        if (fr == 11) letter = m_second ? 3 : 1;
      end else begin
        if (fr == 5)  letter = 0;
        if (fr == 11) letter = 1;
        if (fr == 17) letter = 2;
        if (fr == 23) letter = 3;
      end
      if (bt != 7) letter = -1;
      if (letter >= 0) begin
        if (!t1_ins_en) it.tag = "R4 global off";
        else if (!m_en[who]) it.tag = "R5 channel off";
        else begin
          it.exp_d = ref_letter(who, letter);
          it.tag   = t1_d4 ? "R8 R6 R2 R1 d4 letter" : "R7 R6 R2 R1 esf letter";
        end
      end
    end else if (ch == 16 && fr >= 1 && fr <= 15) begin
      who    = (bt < 4) ? fr : fr + 15;
      letter = bt % 4;
      if (!e1_ins_en) it.tag = "R4 global off";
      else if (!m_en[who]) it.tag = "R5 channel off";
      else begin
        it.exp_d = ref_letter(who, letter);
        it.tag   = "R9 R6 R2 R1 e1 cas";
      end
    end

    // reference update at the edge
    is_d4 = !mode_e1 && t1_d4;
    load  = 1'b0;
    if (mfs) begin
      if (!is_d4)        begin load = 1'b1; m_second = 1'b1; end
      else if (m_second) begin load = 1'b1; m_second = 1'b0; end
      else               m_second = 1'b1;
    end
    if (load) for (int i = 0; i < 16; i++) m_shadow[i] = m_bank[i];
    if (load) m_irq = 1'b1;
    else if (irq_clr) m_irq = 1'b0;
    if (wr_en) begin
      if (wr_addr < 16) m_bank[wr_addr] = wr_data;
      else if (wr_addr < 20) m_en[(int'(wr_addr) - 16) * 8 +: 8] = wr_data;
    end
    it.exp_irq = m_irq;
    q.push_back(it);
  endtask

  task automatic host_wr(input int addr, input int data);
    pend_wr   = 1'b1;
    pend_addr = 5'(addr);
    pend_data = 8'(data);
    step(1'b0, 0, 0, 0);
  endtask

  task automatic run_mf();
    int nfr;
    int nch;
    nfr = mode_e1 ? 16 : (t1_d4 ? 12 : 24);
    nch = mode_e1 ? 32 : 24;
    for (int f = 0; f < nfr; f++)
      for (int c = 0; c < nch; c++)
        for (int b = 0; b < 8; b++) begin
          if (f == 3 && c == 2 && b == 0) begin
            pend_wr   = 1'b1;
            pend_addr = 5'($urandom % (mode_e1 ? 16 : 12));
            pend_data = 8'($urandom);
          end
          if (f == 7 && c == 0 && b == 0) pend_clr = 1'b1;
          step(f == 0 && c == 0 && b == 0, f, c, b);
        end
  endtask

  // monitor: compares each registered result one edge after its inputs
  always @(posedge clk) begin
    item_t it;
    #2;
    if (q.size() > 0) begin
      it = q.pop_front();
      n_chk++;
      if (data_out !== it.exp_d) begin
        n_err++;
        $display("FAIL %s: data_out=%0b expected=%0b", it.tag, data_out, it.exp_d);
      end
      n_chk++;
      if (mf_irq !== it.exp_irq) begin
        n_err++;
        $display("FAIL R3 mf_irq=%0b expected=%0b", mf_irq, it.exp_irq);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_bank[i] = '0; m_shadow[i] = '0; end
    repeat (3) @(negedge clk);
    n_chk++;
    if (data_out !== 1'b0 || mf_irq !== 1'b0) begin
      n_err++;
      $display("FAIL R10 reset: data_out=%0b mf_irq=%0b expected=0 0", data_out, mf_irq);
    end
    rst_n = 1'b1;

    // T1 ESF setup; the shadow is still zero before the first boundary (R10)
    t1_ins_en = 1'b1;
    host_wr(16, 8'hFF);
    host_wr(17, 8'hFF);
    host_wr(18, 8'hFF);
    for (int c = 0; c < 6; c++) step(1'b0, 5, c, 7);
    for (int i = 0; i < 16; i++) host_wr(i, $urandom);
    host_wr(16, 8'hB7);
    host_wr(17, 8'hFD);
    host_wr(18, 8'h7E);
    host_wr(19, 8'hEF);
    host_wr(21, 8'h00); // unmapped: ignored (R1)
    host_wr(28, 8'h00);
    repeat (2) run_mf();

    // T1 D4: alternate boundaries copy (R8)
    t1_d4 = 1'b1;
    repeat (5) run_mf();

    // E1 CAS (R9)
    mode_e1   = 1'b1;
    e1_ins_en = 1'b1;
    host_wr(16, 8'hF6);
    host_wr(17, 8'hDF);
    host_wr(18, 8'hFB);
    repeat (3) run_mf();

    // E1 with the global enable off (R4)
    e1_ins_en = 1'b0;
    run_mf();

    // T1 ESF with the global enable off (R4)
    mode_e1   = 1'b0;
    t1_d4     = 1'b0;
    t1_ins_en = 1'b0;
    run_mf();

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule